// File: doc/BRIEF.md
# Multi-phase instruction cycle sequencer

This block produces the timing strobes that carry a small processor through one instruction after another. Each instruction occupies a frame of one-hot phase enables. Operand loading comes first, then a longer compute stretch, then write-back. A short decode stretch can be placed ahead of the load phases when the prefix enable is high at the moment a frame begins. Each phase lasts one clock unless the sequencer is waiting for the memory side to confirm its write.

Once the write is confirmed, the sequencer tells the program counter to move on. It then spends exactly one cycle flushing intermediate gating state, with no phase enabled. After that it starts the next frame at once and raises a fetch request in that frame's first cycle. After a reset the sequencer waits in idle until a start pulse arrives. From then on it runs frames back to back.

Top module: `instr_phase_seq`

## Requirements
- R1: A synchronous active-high reset leaves the block idle: busy, flush, fetch, pc_step and every phase enable are low in the cycle after reset is sampled.
- R2: In idle, start sampled high at a clock edge makes busy rise and the first phase begin from the next cycle. Start has no effect while busy is high.
- R3: The phase enables are bits of phase_oh. Bits 4..7 form the load window, bits 8..15 form the compute window and bits 16..19 form the store window. Without the prefix, a frame steps through bits 4 to 19 one per cycle, which is 16 phases. win_load, win_exec and win_store are high exactly while a bit of their window is high.
- R4: If pre_en is high at the edge that starts a frame, the frame begins at bit 0 and first runs the decode window, bits 0..3, with win_dec high. This gives 20 phases. pre_en has no effect at any other time.
- R5: While bit 19 is high and wr_done is low, the sequencer holds bit 19 and does not advance.
- R6: pc_step is high exactly in a cycle where bit 19 is high and wr_done is high.
- R7: The cycle after pc_step is a flush cycle. flush is high for exactly that one cycle, and every phase enable is low during it.
- R8: After a flush cycle, the next cycle starts a new frame. fetch is high exactly in the first cycle of every frame, including the first frame after start.
- R9: While busy is high and flush is low, exactly one bit of phase_oh is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts the first frame when idle |
| wr_done | input | 1 | Write-back complete handshake |
| pre_en | input | 1 | Adds the decode window to the frame that is starting |
| phase_oh | output | 20 | One-hot phase enables (PRE_LEN+LOAD_LEN+EXEC_LEN+STORE_LEN) |
| win_dec | output | 1 | Decode window active |
| win_load | output | 1 | Load window active |
| win_exec | output | 1 | Compute window active |
| win_store | output | 1 | Store window active |
| flush | output | 1 | Single-cycle flush slot |
| fetch | output | 1 | Fetch request, first cycle of a frame |
| pc_step | output | 1 | Completion signal to the program counter |
| busy | output | 1 | Sequencer running |

## Verification
The bench builds the block with its default window lengths: a 4-phase decode prefix and 4, 8 and 4 phases for load, compute and store. That makes a frame short enough that every sweep point covers many complete frames. The sweep crosses four pre_en patterns with four wr_done arrival patterns. The pre_en patterns are never high, always high, toggling every cycle and pseudo-random. The wr_done patterns range from always high to present only one cycle in four. Together they reach stalls of several cycles in the last store phase, frames with and without the prefix chained back to back, and pre_en changing in the middle of a frame. Start pulses during a run and resets in the middle of a frame are also included.

// File: rtl/instr_phase_seq.sv
module instr_phase_seq #(
  parameter int PRE_LEN   = 4,
  parameter int LOAD_LEN  = 4,
  parameter int EXEC_LEN  = 8,
  parameter int STORE_LEN = 4
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic                                            start,
  input  logic                                            wr_done,
  input  logic                                            pre_en,
  output logic [PRE_LEN+LOAD_LEN+EXEC_LEN+STORE_LEN-1:0]  phase_oh,
  output logic                                            win_dec,
  output logic                                            win_load,
  output logic                                            win_exec,
  output logic                                            win_store,
  output logic                                            flush,
  output logic                                            fetch,
  output logic                                            pc_step,
  output logic                                            busy
);
  localparam int NPH = PRE_LEN + LOAD_LEN + EXEC_LEN + STORE_LEN;
  localparam int PW  = $clog2(NPH);
  localparam logic [PW-1:0] LD0  = PW'(PRE_LEN);
  localparam logic [PW-1:0] EX0  = PW'(PRE_LEN + LOAD_LEN);
  localparam logic [PW-1:0] ST0  = PW'(PRE_LEN + LOAD_LEN + EXEC_LEN);
  localparam logic [PW-1:0] LAST = PW'(NPH - 1);

  logic          busy_q, flush_q, fetch_q;
  logic [PW-1:0] ph_q;

  wire run     = busy_q & ~flush_q;
  wire at_last = run & (ph_q == LAST);
  wire entry   = (~busy_q & start) | flush_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      flush_q <= 1'b0;
      fetch_q <= 1'b0;
      ph_q    <= '0;
    end else begin
      fetch_q <= entry;
      if (entry) begin
        busy_q  <= 1'b1;
        flush_q <= 1'b0;
        ph_q    <= pre_en ? '0 : LD0;
      end else if (at_last) begin
        if (wr_done) flush_q <= 1'b1;
      end else if (run) begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign phase_oh  = run ? ({{(NPH-1){1'b0}}, 1'b1} << ph_q) : '0;
  assign win_dec   = run & (ph_q < LD0);
  assign win_load  = run & (ph_q >= LD0) & (ph_q < EX0);
  assign win_exec  = run & (ph_q >= EX0) & (ph_q < ST0);
  assign win_store = run & (ph_q >= ST0);
  assign flush     = flush_q;
  assign fetch     = fetch_q;
  assign pc_step   = at_last & wr_done;
  assign busy      = busy_q;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !flush && !fetch && phase_oh == '0));
  a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && fetch));
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_oh[NPH-1] && !wr_done) |=> phase_oh[NPH-1]);
  a_r7_flush_after_step: assert property (@(posedge clk) disable iff (rst)
    pc_step |=> (flush && phase_oh == '0));
  a_r7_flush_single: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);
  a_r8_fetch_after_flush: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fetch && $countones(phase_oh) == 1));
  a_r9_one_phase: assert property (@(posedge clk) disable iff (rst)
    (busy && !flush) |-> ($countones(phase_oh) == 1));
endmodule

// File: tb/tb_instr_phase_seq.sv
module tb_instr_phase_seq;
  localparam int PERIOD = 10;
  localparam int PRE = 4, LD = 4, EX = 8, ST = 4;
  localparam int NPH = PRE + LD + EX + ST;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, wr_done = 1'b0, pre_en = 1'b0;
  logic [NPH-1:0] phase_oh;
  logic win_dec, win_load, win_exec, win_store, flush, fetch, pc_step, busy;

  instr_phase_seq #(.PRE_LEN(PRE), .LOAD_LEN(LD), .EXEC_LEN(EX), .STORE_LEN(ST)) dut (
    .clk(clk), .rst(rst), .start(start), .wr_done(wr_done), .pre_en(pre_en),
    .phase_oh(phase_oh), .win_dec(win_dec), .win_load(win_load), .win_exec(win_exec),
    .win_store(win_store), .flush(flush), .fetch(fetch), .pc_step(pc_step), .busy(busy));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit m_busy = 0, m_flush = 0, m_fetch = 0;
  int m_ph = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit run;
    logic [NPH-1:0] eoh;
    run = m_busy && !m_flush;
    eoh = run ? (NPH'(1) << m_ph) : '0;
    chk("R3 R4 R5 R9 phase", 32'(phase_oh), 32'(eoh));
    chk("R3 R4 windows", {28'd0, win_dec, win_load, win_exec, win_store},
        {28'd0, run && m_ph < PRE, run && m_ph >= PRE && m_ph < PRE+LD,
         run && m_ph >= PRE+LD && m_ph < PRE+LD+EX, run && m_ph >= PRE+LD+EX});
    chk("R7 flush", 32'(flush), 32'(m_flush));
    chk("R8 fetch", 32'(fetch), 32'(m_fetch));
    chk("R6 pc_step", 32'(pc_step), 32'(run && m_ph == NPH-1 && wr_done));
    chk("R2 busy", 32'(busy), 32'(m_busy));
  endtask

  task automatic model_edge();
    bit entry;
    if (rst) begin
      m_busy = 0; m_flush = 0; m_fetch = 0; m_ph = 0;
      return;
    end
    entry = (!m_busy && start) || m_flush;
    m_fetch = entry;
    if (entry) begin
      m_busy = 1; m_flush = 0; m_ph = pre_en ? 0 : PRE;
    end else if (m_busy && m_ph == NPH-1) begin
      if (wr_done) m_flush = 1;
    end else if (m_busy) begin
      m_ph++;
    end
  endtask

  task automatic cycle(input bit r, input bit s, input bit w, input bit p);
    @(negedge clk);
    rst = r; start = s; wr_done = w; pre_en = p;
    #1 compare();
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cycle(1, 0, 0, 0);
    cycle(1, 1, 1, 1);
    @(negedge clk); rst = 0; start = 0;
    #1;
    chk("R1 reset idle", {phase_oh, busy, flush, fetch, pc_step},
        {{NPH{1'b0}}, 4'b0000});
    for (int i = 0; i < 5; i++) cycle(0, 0, 1, 1);
    cycle(0, 1, 0, 0);
    for (int i = 0; i < 15; i++) cycle(0, 0, 0, 0);
    for (int i = 0; i < 10; i++) cycle(0, 0, 0, 0);
    chk("R5 stall at last store", 32'(phase_oh[NPH-1]), 32'd1);
    cycle(0, 0, 1, 1);
    for (int pp = 0; pp < 4; pp++) begin
      for (int k = 0; k < 4; k++) begin
        cycle(1, 0, 0, 0);
        for (int c = 0; c < 140; c++) begin
          bit p, w, s;
          case (pp)
            0: p = 0;
            1: p = 1;
            2: p = c[0];
            default: p = $urandom_range(0, 1);
          endcase
          w = (c % (k + 1)) == 0;
          s = (c == 2) || (c % 37 == 5);
          cycle((c == 90 && k == 2), s, w, p);
        end
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule